// File: doc/BRIEF.md
# External Oscillator Failure Monitor

This block supervises a crystal or external clock source feeding a chip's clock tree. Software turns the supervision on with a single control bit. Monitoring starts only once the oscillator is switched on and reports that its startup delay has completed. From then on, the block runs on a trusted reference clock. It passes the monitored clock through a synchronizer and counts reference cycles between the rising edges it sees. If the gap between rising edges grows too long, the source is declared dead.

On a failure, the block forces the oscillator off and raises an interrupt flag that drives a non-maskable interrupt line. The flag holds until software pulses a clear strobe. If the failing oscillator was the active system clock at that moment, the clock selector also receives a one-cycle request to fall back to the internal 16 MHz oscillator. After a failure, the monitor stays locked out. It arms again only when software has switched the oscillator off and back on and the startup delay has completed again.

Top module: `xosc_guard`

## Requirements
- R1: After synchronous reset, `nmi_o`, `xosc_kill_o` and `fallback_req_o` are all 0.
- R2: While `mon_en_i` is 0, a stopped monitored clock never raises `nmi_o` or `xosc_kill_o`.
- R3: While `xosc_rdy_i` is 0, the startup delay has not completed, so no failure is detected.
- R4: While `xosc_on_i` is 0, the monitor is disarmed and detects no failure.
- R5: A failure is declared in the 64th consecutive armed reference cycle in which the twice-synchronized monitored clock shows no rising edge. The outputs change on the following clock edge. An edge period of 60 reference cycles never fails, and a period of 70 does fail.
- R6: On a failure, `xosc_kill_o` goes to 1 and stays at 1 until `xosc_on_i` is 0, and it drops on the edge after that.
- R7: `nmi_o` is set by a failure and stays at 1 until `irq_clr_i` is sampled at 1. It is 0 on the following cycle.
- R8: If a clear strobe and a failure occur in the same cycle, `nmi_o` is 1 afterwards.
- R9: `fallback_req_o` is a single-cycle pulse. It appears alongside the flag only when `xosc_is_sys_i` was 1 in the failing cycle.
- R10: After a failure, no further failure is detected until `xosc_on_i` has been 0 and the arming conditions are met again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en_i | input | 1 | Software enable of the monitor |
| xosc_on_i | input | 1 | Oscillator enable bit as seen by software |
| xosc_rdy_i | input | 1 | Oscillator startup delay complete |
| xosc_clk_i | input | 1 | Monitored oscillator clock (asynchronous) |
| xosc_is_sys_i | input | 1 | Oscillator currently drives the system clock |
| irq_clr_i | input | 1 | Clear strobe for the interrupt flag |
| nmi_o | output | 1 | Sticky failure flag, non-maskable interrupt |
| xosc_kill_o | output | 1 | Forces the oscillator off |
| fallback_req_o | output | 1 | One-cycle request to switch to the internal oscillator |

## Verification
The monitored clock is driven with a fast toggle and with periods just below and just above the 64-cycle window, which tells correct window sizing apart from off-by-one errors. A source that stops outright shows the exact failure cycle. Stopping the source while each arming condition is missing in turn (enable, ready, on) separates correct gating from a detector that runs free. Two further patterns are needed: a clear that is held across the failure cycle, and a restart after lock-out. They distinguish the flag's set-over-clear priority and the re-arm sequence from a simple level follower.

// File: rtl/xfm_pkg.sv
package xfm_pkg;
  typedef enum logic [1:0] {
    ARM_IDLE   = 2'd0,
    ARM_ACTIVE = 2'd1,
    ARM_LOCKED = 2'd2
  } arm_state_t;
endpackage

// File: rtl/xfm_sync.sv
module xfm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xfm_window.sv
module xfm_window #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic sync_i,
  output logic fail_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic             prev_q;
  logic             rise;
  logic [CNT_W-1:0] gap_q;

  assign rise   = sync_i & ~prev_q;
  assign fail_o = active_i & ~rise & (gap_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !active_i || rise || fail_o) gap_q <= '0;
    else                                    gap_q <= gap_q + 1'b1;
  end

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    gap_q <= LAST); // R5
endmodule

// File: rtl/xfm_arm.sv
module xfm_arm
  import xfm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic on_i,
  input  logic rdy_i,
  input  logic fail_i,
  output logic active_o,
  output logic kill_o
);
  arm_state_t st_q, st_d;
  logic       qual;

  assign qual     = en_i & on_i & rdy_i;
  assign active_o = (st_q == ARM_ACTIVE) & qual;
  assign kill_o   = (st_q == ARM_LOCKED);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ARM_IDLE:   if (qual) st_d = ARM_ACTIVE;
      ARM_ACTIVE: if (fail_i) st_d = ARM_LOCKED;
                  else if (!qual) st_d = ARM_IDLE;
      ARM_LOCKED: if (!on_i) st_d = ARM_IDLE;
      default:    st_d = ARM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ARM_IDLE;
    else     st_q <= st_d;
  end

  AST_KILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    kill_o && on_i |=> kill_o); // R6
  AST_LOCK_NO_FAIL: assert property (@(posedge clk) disable iff (rst)
    kill_o |-> !fail_i); // R10
endmodule

// File: rtl/xfm_flag.sv
module xfm_flag (
  input  logic clk,
  input  logic rst,
  input  logic fail_i,
  input  logic clr_i,
  input  logic sel_i,
  output logic nmi_o,
  output logic fb_o
);
  always_ff @(posedge clk) begin
    if (rst)         nmi_o <= 1'b0;
    else if (fail_i) nmi_o <= 1'b1;
    else if (clr_i)  nmi_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) fb_o <= 1'b0;
    else     fb_o <= fail_i & sel_i;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    nmi_o && !clr_i |=> nmi_o); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    fail_i && clr_i |=> nmi_o); // R8
  AST_FB_PULSE: assert property (@(posedge clk) disable iff (rst)
    fb_o |=> !fb_o); // R9
endmodule

// File: rtl/xosc_guard.sv
module xosc_guard #(
  parameter int WINDOW      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_en_i,
  input  logic xosc_on_i,
  input  logic xosc_rdy_i,
  input  logic xosc_clk_i,
  input  logic xosc_is_sys_i,
  input  logic irq_clr_i,
  output logic nmi_o,
  output logic xosc_kill_o,
  output logic fallback_req_o
);
  logic sync_clk;
  logic active;
  logic fail;

  xfm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(xosc_clk_i), .q_o(sync_clk));

  xfm_window #(.WINDOW(WINDOW)) u_window (
    .clk(clk), .rst(rst), .active_i(active), .sync_i(sync_clk), .fail_o(fail));

  xfm_arm u_arm (
    .clk(clk), .rst(rst), .en_i(mon_en_i), .on_i(xosc_on_i), .rdy_i(xosc_rdy_i),
    .fail_i(fail), .active_o(active), .kill_o(xosc_kill_o));

  xfm_flag u_flag (
    .clk(clk), .rst(rst), .fail_i(fail), .clr_i(irq_clr_i), .sel_i(xosc_is_sys_i),
    .nmi_o(nmi_o), .fb_o(fallback_req_o));

  AST_ARM_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(xosc_kill_o) |-> $past(mon_en_i) && $past(xosc_rdy_i)); // R3
  AST_ARM_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(xosc_kill_o) |-> $past(xosc_on_i)); // R4
  AST_FB_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    fallback_req_o |-> $past(xosc_is_sys_i) && nmi_o); // R9
endmodule

// File: tb/test_xosc_guard.sv
module test_xosc_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, on = 1'b0, rdy = 1'b0, xclk = 1'b0, sel = 1'b0, clr = 1'b0;
  logic nmi, kill, fb;
  int   tests = 0, fails = 0;
  int   xhalf = 0, xcnt = 0;

  always #5 clk = ~clk;

  xosc_guard i_xosc_guard (
    .clk(clk), .rst(rst), .mon_en_i(en), .xosc_on_i(on), .xosc_rdy_i(rdy),
    .xosc_clk_i(xclk), .xosc_is_sys_i(sel), .irq_clr_i(clr),
    .nmi_o(nmi), .xosc_kill_o(kill), .fallback_req_o(fb));

  // monitored clock: toggles every xhalf reference cycles, stopped when 0
  always @(negedge clk) begin
    if (xhalf > 0) begin
      xcnt++;
      if (xcnt >= xhalf) begin xclk <= ~xclk; xcnt = 0; end
    end
  end

  // behavioural reference model
  bit hist[$] = '{0, 0, 0};
  int m_st = 0, m_cnt = 0;
  bit m_nmi = 0, m_kill = 0, m_fb = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0}; m_st = 0; m_cnt = 0; m_nmi = 0; m_fb = 0;
    end else begin
      bit q, act, edg, f;
      q   = en && on && rdy;
      act = (m_st == 1) && q;
      edg = hist[1] && !hist[2];
      f   = act && !edg && (m_cnt == 63);
      m_cnt = (!act || edg || f) ? 0 : m_cnt + 1;
      if (f) m_nmi = 1; else if (clr) m_nmi = 0;
      m_fb = f && sel;
      if (m_st == 0 && q) m_st = 1;
      else if (m_st == 1 && f) m_st = 2;
      else if (m_st == 1 && !q) m_st = 0;
      else if (m_st == 2 && !on) m_st = 0;
      hist = '{xclk, hist[0], hist[1]};
    end
    m_kill = (m_st == 2);
  end

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R7 model nmi", nmi, m_nmi);
      check("R6 model kill", kill, m_kill);
      check("R9 model fallback", fb, m_fb);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    check("R1 nmi", nmi, 1'b0);
    check("R1 kill", kill, 1'b0);
    check("R1 fallback", fb, 1'b0);

    on = 1; rdy = 1; en = 0; xhalf = 0;
    cyc(200);
    check("R2 disabled", nmi | kill, 1'b0);

    en = 1; rdy = 0;
    cyc(200);
    check("R3 not ready", nmi | kill, 1'b0);

    on = 0; rdy = 1;
    cyc(200);
    check("R4 osc off", nmi | kill, 1'b0);
    on = 1; xhalf = 3;
    cyc(100);
    on = 0; xhalf = 0;
    cyc(200);
    check("R4 stopped after off", nmi | kill, 1'b0);

    on = 1; xhalf = 30;
    cyc(600);
    check("R5 period 60 ok", nmi, 1'b0);
    xhalf = 35;
    for (int i = 0; i < 300 && !kill; i++) cyc(1);
    check("R5 period 70 fails", nmi, 1'b1);
    check("R6 kill on fail", kill, 1'b1);
    check("R9 no fallback when not selected", fb, 1'b0);

    xhalf = 0;
    cyc(300);
    check("R6 kill held", kill, 1'b1);
    check("R7 flag held", nmi, 1'b1);
    clr = 1; cyc(1); clr = 0; cyc(1);
    check("R7 flag cleared", nmi, 1'b0);
    cyc(300);
    check("R10 locked stop", nmi, 1'b0);
    xhalf = 3; cyc(50); xhalf = 0; cyc(200);
    check("R10 locked restart", nmi, 1'b0);

    on = 0; rdy = 0; cyc(2);
    check("R6 kill released", kill, 1'b0);
    on = 1; cyc(100);
    check("R3 restart not ready", nmi | kill, 1'b0);
    rdy = 1; xhalf = 4; cyc(200);
    check("R10 rearmed running", nmi, 1'b0);

    sel = 1; clr = 1; xhalf = 0;
    for (int i = 0; i < 300 && !kill; i++) cyc(1);
    check("R8 set beats clear", nmi, 1'b1);
    check("R9 fallback pulse", fb, 1'b1);
    cyc(1);
    check("R9 fallback one cycle", fb, 1'b0);
    check("R7 held clear wins later", nmi, 1'b0);
    clr = 0;
    cyc(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule